// File: doc/BRIEF.md
# Oscillator tuning-matrix cell decoder

This block turns a 10-bit tuning word into one enable bit for every cell of a two-dimensional array of switchable driver cells. The array sits beside a ring-oscillator delay line. It has one column per ring stage and a fixed number of rows. Each enabled cell adds drive current to its stage, so more enabled cells give a faster oscillator. Three fine-tune driver cells take their own enables from the two low code bits. A separate trim vector drives a reserved group of cells, and the tuning code never touches that group.

A fill-mode input selects how the coarse part of the code walks through the matrix:
- **Row-first:** fill along a row, then move to the next row.
- **Column-first:** fill down a column, then move to the next column.
- **Rectangle:** the column count and the row count are two separate thermometers, and a cell is enabled where both are set.

All enables are computed combinationally. They reach the outputs only on a cycle where the load strobe is high, so the oscillator sees one clean update per strobe. Reset clears every enable, which gives the slowest oscillator setting.

Top module: `osc_tune_decoder`

## Requirements
- R1: Cell (row r, column c) drives bit r*N_COLS+c of `cell_en`. Bit 0 is the top-left cell, and rows and columns count from 0. In row-first mode (`fill_mode`=0), and also for the unused value 3, a coarse count K enables exactly bits 0 to K-1.
- R2: In column-first mode (`fill_mode`=1), the coarse cells are taken column by column, starting at column 0 and running from row 0 downward. Reserved trim cells are skipped. The first K cells in this order are enabled.
- R3: In rectangle mode (`fill_mode`=2), the column count is `tune_code[9:7]`, saturated at N_COLS. The row count is `tune_code[6:1]`, saturated at N_ROWS. A cell is enabled when its column is below the column count and its row is below the row count. Trim cells are never enabled by this rule.
- R4: The coarse count K is `tune_code[9:2]`, in the range 0 to 255. In the row-first and column-first modes, exactly K non-trim cells are enabled.
- R5: The fine value F is `tune_code[1:0]`. It enables `fine_en[0]` up to `fine_en[F-1]` as a thermometer, in every mode. These three cells sit on stage columns 2, 4 and 6.
- R6: The reserved trim cells are the last 11 positions, bits 255 to 265. Bit 255+t always equals `trim_en[t]`, in every mode and for any tuning code.
- R7: The outputs change only on a rising clock edge where `load` is high. At that edge they take the value computed from the inputs present then. If `fill_mode`, `tune_code` or `trim_en` change while `load` is low, the outputs do not change.
- R8: A synchronous active-high `rst` clears `cell_en` and `fine_en` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture strobe for all enables |
| fill_mode | input | 2 | 0 row-first, 1 column-first, 2 rectangle, 3 as row-first |
| tune_code | input | 10 | Tuning word: coarse count [9:2], fine value [1:0] |
| trim_en | input | 11 | Enables for the reserved trim cells |
| cell_en | output | 266 | Registered matrix cell enables, bit r*7+c |
| fine_en | output | 3 | Registered fine-cell enables |

## Verification
Coarse filling and trim passing meet in the same load cycle. With a coarse count of 255, the last coarse cell (bit 254) lies right next to the first trim cell (bit 255). The bench therefore loads a full coarse count in both fill modes together with alternating and all-ones trim patterns in one strobe. It then compares the whole 266-bit vector against a model that walks the fill order independently, so any overlap or gap at that boundary shows up as a mismatch. A second collision comes from changing the mode and the code while the strobe is low. There the bench checks that the held value still equals the last loaded expectation.

// File: rtl/osc_tune_pkg.sv
package osc_tune_pkg;

    localparam int CODE_W   = 10;
    localparam int COARSE_W = 8;
    localparam int FINE_W   = 2;
    localparam int XCODE_W  = 3;
    localparam int YCODE_W  = 6;

    typedef enum logic [1:0] {
        FILL_ROW  = 2'b00,
        FILL_COL  = 2'b01,
        FILL_RECT = 2'b10,
        FILL_RSV  = 2'b11
    } fill_mode_e;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } tune_word_t;

    // number of non-reserved cells in column k (reserved cells sit at the tail
    // of row-major order, so valid cells form a contiguous top segment)
    function automatic int col_depth(int k, int ncols, int limit);
        if (limit > k) return (limit - k + ncols - 1) / ncols;
        return 0;
    endfunction

    // position of cell (r,c) in column-first order among non-reserved cells
    function automatic int col_rank(int r, int c, int ncols, int limit);
        int acc;
        acc = 0;
        for (int k = 0; k < c; k++) acc += col_depth(k, ncols, limit);
        return acc + r;
    endfunction

endpackage

// File: rtl/fill_map.sv
module fill_map
    import osc_tune_pkg::*;
#(
    parameter int N_COLS       = 7,
    parameter int N_ROWS       = 38,
    parameter int COARSE_LIMIT = 255,
    localparam int CELLS       = N_COLS * N_ROWS
) (
    input  fill_mode_e           mode,
    input  logic [COARSE_W-1:0]  coarse_cnt,
    input  logic [XCODE_W-1:0]   x_code,
    input  logic [YCODE_W-1:0]   y_code,
    output logic [CELLS-1:0]     coarse_map
);

    int x_cnt;
    int y_cnt;
    int k_cnt;

    always_comb begin
        k_cnt = int'(coarse_cnt);
        x_cnt = (int'(x_code) > N_COLS) ? N_COLS : int'(x_code);
        y_cnt = (int'(y_code) > N_ROWS) ? N_ROWS : int'(y_code);
    end

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        for (genvar c = 0; c < N_COLS; c++) begin : g_col
            localparam int POS  = r * N_COLS + c;
            localparam int RANK = col_rank(r, c, N_COLS, COARSE_LIMIT);
            if (POS >= COARSE_LIMIT) begin : g_rsv
                assign coarse_map[POS] = 1'b0;
            end else begin : g_act
                always_comb begin
                    unique case (mode)
                        FILL_COL:  coarse_map[POS] = (RANK < k_cnt);
                        FILL_RECT: coarse_map[POS] = (c < x_cnt) && (r < y_cnt);
                        default:   coarse_map[POS] = (POS < k_cnt);
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/fine_therm.sv
module fine_therm
    import osc_tune_pkg::*;
#(
    parameter int FINE_CELLS = 3
) (
    input  logic [FINE_W-1:0]     fine_val,
    output logic [FINE_CELLS-1:0] fine_map
);

    for (genvar k = 0; k < FINE_CELLS; k++) begin : g_fine
        assign fine_map[k] = (int'(fine_val) > k);
    end

endmodule

// File: rtl/enable_reg.sv
module enable_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (q == '0)); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q)); // R7

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d))); // R7

endmodule

// File: rtl/osc_tune_decoder.sv
module osc_tune_decoder
    import osc_tune_pkg::*;
#(
    parameter int N_COLS     = 7,
    parameter int N_ROWS     = 38,
    parameter int TRIM_CELLS = 11,
    parameter int FINE_CELLS = 3,
    localparam int CELLS     = N_COLS * N_ROWS,
    localparam int COARSE_LIMIT = CELLS - TRIM_CELLS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [1:0]            fill_mode,
    input  logic [CODE_W-1:0]     tune_code,
    input  logic [TRIM_CELLS-1:0] trim_en,
    output logic [CELLS-1:0]      cell_en,
    output logic [FINE_CELLS-1:0] fine_en
);

    tune_word_t              word;
    fill_mode_e              mode;
    logic [CELLS-1:0]        coarse_map;
    logic [CELLS-1:0]        next_cells;
    logic [FINE_CELLS-1:0]   next_fine;

    assign word = tune_word_t'(tune_code);
    assign mode = fill_mode_e'(fill_mode);

    fill_map #(
        .N_COLS       (N_COLS),
        .N_ROWS       (N_ROWS),
        .COARSE_LIMIT (COARSE_LIMIT)
    ) u_fill (
        .mode       (mode),
        .coarse_cnt (word.coarse),
        .x_code     (tune_code[CODE_W-1 -: XCODE_W]),
        .y_code     (tune_code[CODE_W-1-XCODE_W -: YCODE_W]),
        .coarse_map (coarse_map)
    );

    fine_therm #(.FINE_CELLS(FINE_CELLS)) u_fine (
        .fine_val (word.fine),
        .fine_map (next_fine)
    );

    // reserved cells are driven only by the trim vector
    for (genvar p = 0; p < CELLS; p++) begin : g_merge
        if (p >= COARSE_LIMIT) begin : g_trim
            assign next_cells[p] = trim_en[p - COARSE_LIMIT];
        end else begin : g_coarse
            assign next_cells[p] = coarse_map[p];
        end
    end

    enable_reg #(.WIDTH(CELLS)) u_cell_reg (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (next_cells),
        .q    (cell_en)
    );

    enable_reg #(.WIDTH(FINE_CELLS)) u_fine_reg (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (next_fine),
        .q    (fine_en)
    );

    localparam logic [CELLS-1:0] COARSE_MASK = {{TRIM_CELLS{1'b0}}, {COARSE_LIMIT{1'b1}}};

    AST_FILL_COUNT: assert property (@(posedge clk) disable iff (rst)
        (load && fill_mode != 2'b10) |=>
            ($countones(cell_en & COARSE_MASK) == int'($past(tune_code[CODE_W-1:FINE_W])))); // R4

    AST_TRIM_PASS: assert property (@(posedge clk) disable iff (rst)
        load |=> (cell_en[CELLS-1 -: TRIM_CELLS] == $past(trim_en))); // R6

    AST_FINE_COUNT: assert property (@(posedge clk) disable iff (rst)
        load |=> ($countones(fine_en) == int'($past(tune_code[FINE_W-1:0])))); // R5

    AST_RECT_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        (load && fill_mode == 2'b10 && tune_code[9:7] != 3'd0 && tune_code[6:1] != 6'd0)
            |=> cell_en[0]); // R3

endmodule

// File: tb/osc_tune_decoder_tb.sv
module osc_tune_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 7;
    localparam int NR = 38;
    localparam int NT = 11;
    localparam int NCELL = NC * NR;
    localparam int LIM = NCELL - NT;

    typedef struct {
        logic [NCELL-1:0] cells;
        logic [2:0]       fine;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             load = 1'b0;
    logic [1:0]       fill_mode = 2'b00;
    logic [9:0]       tune_code = '0;
    logic [NT-1:0]    trim_en = '0;
    logic [NCELL-1:0] cell_en;
    logic [2:0]       fine_en;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    exp_t sb_q[$];
    exp_t last_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_tune_decoder dut_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .fill_mode (fill_mode),
        .tune_code (tune_code),
        .trim_en   (trim_en),
        .cell_en   (cell_en),
        .fine_en   (fine_en)
    );

    function automatic exp_t model(logic [1:0] m, logic [9:0] code, logic [NT-1:0] tr, string tag);
        exp_t e;
        int k;
        int xc;
        int yc;
        int f;
        e.cells = '0;
        e.tag = tag;
        k = int'(code[9:2]);
        if (m == 2'b01) begin
            int n = 0;
            for (int c = 0; c < NC; c++)
                for (int r = 0; r < NR; r++)
                    if (r * NC + c < LIM) begin
                        if (n < k) e.cells[r * NC + c] = 1'b1;
                        n++;
                    end
        end else if (m == 2'b10) begin
            xc = int'(code[9:7]); if (xc > NC) xc = NC;
            yc = int'(code[6:1]); if (yc > NR) yc = NR;
            for (int r = 0; r < yc; r++)
                for (int c = 0; c < xc; c++)
                    if (r * NC + c < LIM) e.cells[r * NC + c] = 1'b1;
        end else begin
            for (int p = 0; p < k; p++) e.cells[p] = 1'b1;
        end
        for (int t = 0; t < NT; t++) e.cells[LIM + t] = tr[t];
        f = int'(code[1:0]);
        e.fine = '0;
        for (int i = 0; i < f; i++) e.fine[i] = 1'b1;
        return e;
    endfunction

    task automatic check(string tag, logic [NCELL-1:0] ac, logic [2:0] af,
                         logic [NCELL-1:0] ec, logic [2:0] ef);
        total++;
        if (ac !== ec || af !== ef) begin
            bad++;
            $display("FAIL %s cells=%h exp=%h fine=%b exp=%b", tag, ac, ec, af, ef);
        end
    endtask

    // monitor: pops expected items when a load edge has produced a result
    initial begin
        forever begin
            bit pend;
            @(posedge clk);
            pend = load && !rst;
            @(negedge clk);
            if (pend) begin
                if (sb_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R7 unexpected load cells=%h exp=none", cell_en);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(e.tag, cell_en, fine_en, e.cells, e.fine);
                end
            end
        end
    end

    task automatic drive_load(logic [1:0] m, logic [9:0] code, logic [NT-1:0] tr, string tag);
        exp_t e;
        @(negedge clk);
        fill_mode = m; tune_code = code; trim_en = tr; load = 1'b1;
        e = model(m, code, tr, tag);
        sb_q.push_back(e);
        last_exp = e;
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        total++; bad++;
        $display("FAIL watchdog expired cells=%h exp=idle", cell_en);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset state", cell_en, fine_en, '0, '0);
        rst = 1'b0;
        @(negedge clk);

        drive_load(2'b00, {8'd10, 2'd0}, '0, "R1 R4 row-first 10");
        drive_load(2'b00, {8'd255, 2'd0}, '0, "R1 R4 row-first full");
        drive_load(2'b11, {8'd17, 2'd1}, '0, "R1 unused mode as row-first");
        drive_load(2'b01, {8'd40, 2'd2}, '0, "R2 R4 column-first 40");
        drive_load(2'b01, {8'd37, 2'd0}, '0, "R2 column-first one column");
        drive_load(2'b01, {8'd255, 2'd0}, {NT{1'b1}}, "R2 R6 column-first full with trim");
        drive_load(2'b10, {3'd3, 6'd5, 1'b0}, '0, "R3 rectangle 3x5");
        drive_load(2'b10, {3'd7, 6'd63, 1'b1}, '0, "R3 rectangle saturated");
        drive_load(2'b00, {8'd0, 2'd3}, '0, "R5 fine all three");
        drive_load(2'b10, {3'd0, 6'd9, 1'b0}, 11'h2AA, "R6 trim alone");
        drive_load(2'b00, {8'd255, 2'd2}, 11'h555, "R6 coarse meets trim row-first");
        drive_load(2'b01, {8'd200, 2'd1}, 11'h0F3, "R6 coarse meets trim column-first");

        // R7: change every input with load low; outputs must hold
        @(negedge clk);
        fill_mode = 2'b10; tune_code = 10'h3FF; trim_en = '0;
        repeat (3) @(negedge clk);
        check("R7 hold after mode and code change", cell_en, fine_en,
              last_exp.cells, last_exp.fine);
        fill_mode = 2'b01;
        @(negedge clk);
        check("R7 hold after mode change only", cell_en, fine_en,
              last_exp.cells, last_exp.fine);

        // R8: reset in mid run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 mid-run reset", cell_en, fine_en, '0, '0);

        drive_load(2'b00, {8'd1, 2'd0}, 11'h001, "R1 single cell after reset");
        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R7 pending=%0d exp=0", sb_q.size());
        end
        summary();
    end

endmodule